// File: doc/BRIEF.md
# Byte-Stream CRC-8 Frame Guard

This block protects byte transfers on a noisy two-wire serial bus with an 8-bit cyclic redundancy check. Bytes arrive one per clock on a byte-wide input with a valid strobe. Start-of-frame and end-of-frame strobes mark the first and last byte of a transfer, and a direction bit marks the frame as outgoing or incoming. Every byte of the frame is folded into a running CRC register, and the leading control byte is always one of them. The register holds a whole-byte update each clock.

For outgoing frames the block always produces the CRC byte that follows the transfer. For incoming frames the last byte is taken to be the received CRC. It is compared with the CRC of every byte before it, and a mismatch raises a sticky error flag. A software-written enable bit gates only this receive check. It comes out of reset enabled, and clearing it never stops the transmit CRC.

Top module: `crc8_link_guard`

## Requirements
- R1: The CRC uses generator x^8 + x^2 + x + 1 (0x07). Data bits are fed most significant bit first, and there is no final inversion. A start-of-frame byte seeds from 0x00. The nine ASCII bytes "123456789" give 0xF4.
- R2: The first byte of a frame (the control byte) is part of the CRC. A one-byte frame holding 0x01 gives crc_value 0x07.
- R3: One byte is absorbed per clock. crc_value shows the update one cycle after a valid byte, back-to-back frames need no idle cycle, and crc_value holds while byte_vld is low.
- R4: byte_dir is 0 for transmit and 1 for receive. One cycle after a valid end-of-frame byte of a transmit frame, crc_ready is high for exactly one cycle, and crc_value then holds the CRC of all bytes of that frame. crc_ready never pulses for receive frames.
- R5: The transmit CRC and crc_ready behave identically whether checking is enabled or disabled.
- R6: chk_en is 1 after reset. A cycle with chk_en_wr high loads chk_en_dat into chk_en on the next cycle, and chk_en holds otherwise.
- R7: On a receive frame, the byte sent with byte_eof is compared with the CRC of the frame's earlier bytes. When chk_en is 1 and they differ, rx_err is 1 from the next cycle.
- R8: While chk_en is 0, a receive frame never sets rx_err, even with a wrong CRC byte.
- R9: rx_err stays set until a cycle with err_clr high clears it. When a new mismatch and err_clr fall in the same cycle, rx_err stays set.
- R10: After a receive frame whose last byte is its correct CRC, crc_value is 0x00 and rx_err is not set.
- R11: A receive frame of a single byte (start and end together) is compared against the seed 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Byte on byte_dat is valid this cycle |
| byte_sof | input | 1 | Valid byte is the first of a frame |
| byte_eof | input | 1 | Valid byte is the last of a frame |
| byte_dir | input | 1 | Frame direction: 0 transmit, 1 receive |
| byte_dat | input | 8 | Frame byte |
| chk_en_wr | input | 1 | Write strobe for the check-enable bit |
| chk_en_dat | input | 1 | Value written to the check-enable bit |
| err_clr | input | 1 | Write-one-to-clear strobe for rx_err |
| crc_value | output | 8 | Running CRC register |
| crc_ready | output | 1 | One-cycle pulse: crc_value is the transmit CRC to append |
| chk_en | output | 1 | Current check-enable bit |
| rx_err | output | 1 | Sticky receive CRC mismatch flag |

## Verification
The assertions assume well-formed framing: byte_sof and byte_eof are only meaningful with byte_vld, byte_dir stays constant across a frame, and every frame opens with byte_sof before its other bytes. The bench drives frames only through one byte task that raises the strobes together with valid and keeps the direction fixed per frame. It also leaves every strobe low between frames, so no property sees an orphaned end-of-frame or a direction change in mid-frame. The residue property further relies on the generator having its constant term set, which an elaboration check enforces.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } frame_dir_e;

   typedef struct packed {
      logic       vld;
      logic       sof;
      logic       eof;
      frame_dir_e dir;
   } beat_ctl_t;

   // Bit-reverse a vector of up to 32 bits, lower w bits used.
   function automatic logic [31:0] bit_reverse(input logic [31:0] v, input int w);
      logic [31:0] r;
      r = '0;
      for (int k = 0; k < w; k++) begin
         r[w-1-k] = v[k];
      end
      return r;
   endfunction

endpackage

// File: rtl/crc_bitstep.sv
module crc_bitstep #(
   parameter int                CRC_W     = 8,
   parameter int                DATA_W    = 8,
   parameter logic [CRC_W-1:0]  POLY      = 'h07,
   parameter bit                MSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   import crc8_pkg::*;

   localparam logic [31:0]      POLY_WIDE = 32'(POLY);
   localparam logic [31:0]      POLY_REV_WIDE = bit_reverse(POLY_WIDE, CRC_W);
   localparam logic [CRC_W-1:0] POLY_REV = POLY_REV_WIDE[CRC_W-1:0];
   localparam int               STEPS = DATA_W;

   if (CRC_W < 2 || CRC_W > 32) begin : g_bad_width
      $error("crc_bitstep: CRC_W must lie in 2..32");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("crc_bitstep: DATA_W must be positive");
   end

   logic [CRC_W-1:0] chain [STEPS+1];

   assign chain[0] = crc_in;

   for (genvar i = 0; i < STEPS; i++) begin : g_bit
      logic din;
      logic fb;
      if (MSB_FIRST) begin : g_msb
         assign din = data_in[DATA_W-1-i];
         assign fb  = chain[i][CRC_W-1] ^ din;
         assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end else begin : g_lsb
         assign din = data_in[i];
         assign fb  = chain[i][0] ^ din;
         assign chain[i+1] = {1'b0, chain[i][CRC_W-1:1]} ^ (fb ? POLY_REV : '0);
      end
   end

   assign crc_out = chain[STEPS];

endmodule

// File: rtl/crc_frame_acc.sv
module crc_frame_acc #(
   parameter int                CRC_W     = 8,
   parameter logic [CRC_W-1:0]  POLY      = 'h07,
   parameter logic [CRC_W-1:0]  INIT      = '0,
   parameter bit                MSB_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  crc8_pkg::beat_ctl_t    ctl,
   input  logic [CRC_W-1:0]       data,
   output logic [CRC_W-1:0]       crc_prior,
   output logic [CRC_W-1:0]       crc_q,
   output logic                   tx_ready
);
   import crc8_pkg::*;

   logic [CRC_W-1:0] crc_next;

   // Seed selection: a start-of-frame byte ignores what the register holds.
   assign crc_prior = ctl.sof ? INIT : crc_q;

   crc_bitstep #(
      .CRC_W     (CRC_W),
      .DATA_W    (CRC_W),
      .POLY      (POLY),
      .MSB_FIRST (MSB_FIRST)
   ) i_step (
      .crc_in  (crc_prior),
      .data_in (data),
      .crc_out (crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (ctl.vld) begin
         crc_q <= crc_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ready <= 1'b0;
      end else begin
         tx_ready <= ctl.vld && ctl.eof && (ctl.dir == DIR_TX);
      end
   end

   // R3: no byte, no change
   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.vld |=> $stable(crc_q));

   // R4: transmit end-of-frame yields the append pulse
   p_ready_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.vld && ctl.eof && ctl.dir == DIR_TX) |=> tx_ready);

   // R4: pulse only follows a transmit end-of-frame
   p_ready_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> $past(ctl.vld && ctl.eof && ctl.dir == DIR_TX));

endmodule

// File: rtl/crc_rx_judge.sv
module crc_rx_judge #(
   parameter int  CRC_W    = 8,
   parameter bit  EN_RESET = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  crc8_pkg::beat_ctl_t    ctl,
   input  logic [CRC_W-1:0]       data,
   input  logic [CRC_W-1:0]       crc_prior,
   input  logic                   en_wr,
   input  logic                   en_dat,
   input  logic                   err_clr,
   output logic                   chk_en,
   output logic                   rx_err
);
   import crc8_pkg::*;

   logic rx_last;
   logic mismatch;
   logic err_set;

   assign rx_last  = ctl.vld && ctl.eof && (ctl.dir == DIR_RX);
   assign mismatch = (data != crc_prior);
   assign err_set  = rx_last && chk_en && mismatch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_en <= EN_RESET;
      end else if (en_wr) begin
         chk_en <= en_dat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_err <= 1'b0;
      end else if (err_set) begin
         rx_err <= 1'b1;
      end else if (err_clr) begin
         rx_err <= 1'b0;
      end
   end

   // R6: a write lands on the next cycle
   p_en_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (chk_en == $past(en_dat)));

   // R6: no write, no change
   p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(chk_en));

   // R7 / R8: a new error only follows an enabled receive end-of-frame
   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_err) |-> $past(ctl.vld && ctl.eof && ctl.dir == DIR_RX && chk_en));

   // R9: sticky without a clear
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err && !err_clr) |=> rx_err);

   // R9: clear works when no new enabled receive check competes
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !(ctl.vld && ctl.eof && ctl.dir == DIR_RX && chk_en)) |=> !rx_err);

endmodule

// File: rtl/crc8_link_guard.sv
module crc8_link_guard #(
   parameter int                CRC_W     = 8,
   parameter logic [CRC_W-1:0]  POLY      = 'h07,
   parameter logic [CRC_W-1:0]  INIT      = '0,
   parameter bit                MSB_FIRST = 1'b1,
   parameter bit                EN_RESET  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              byte_sof,
   input  logic              byte_eof,
   input  logic              byte_dir,
   input  logic [CRC_W-1:0]  byte_dat,
   input  logic              chk_en_wr,
   input  logic              chk_en_dat,
   input  logic              err_clr,
   output logic [CRC_W-1:0]  crc_value,
   output logic              crc_ready,
   output logic              chk_en,
   output logic              rx_err
);
   import crc8_pkg::*;

   // The received CRC byte is one data beat, so beat width equals CRC width.
   localparam int DATA_W = CRC_W;

   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc8_link_guard: generator needs its constant term for a zero residue");
   end

   beat_ctl_t        ctl;
   logic [CRC_W-1:0] crc_prior;
   logic [DATA_W-1:0] dat;

   assign ctl.vld = byte_vld;
   assign ctl.sof = byte_sof;
   assign ctl.eof = byte_eof;
   assign ctl.dir = frame_dir_e'(byte_dir);
   assign dat     = byte_dat;

   crc_frame_acc #(
      .CRC_W     (CRC_W),
      .POLY      (POLY),
      .INIT      (INIT),
      .MSB_FIRST (MSB_FIRST)
   ) i_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .data      (dat),
      .crc_prior (crc_prior),
      .crc_q     (crc_value),
      .tx_ready  (crc_ready)
   );

   crc_rx_judge #(
      .CRC_W    (CRC_W),
      .EN_RESET (EN_RESET)
   ) i_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .data      (dat),
      .crc_prior (crc_prior),
      .en_wr     (chk_en_wr),
      .en_dat    (chk_en_dat),
      .err_clr   (err_clr),
      .chk_en    (chk_en),
      .rx_err    (rx_err)
   );

   // R10: the accumulator residue and the judge's verdict agree
   p_residue_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_eof && byte_dir && chk_en && !rx_err)
      |=> (rx_err == (crc_value != '0)));

   // R5: transmit completion does not depend on the enable bit
   p_tx_no_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_eof && !byte_dir && !chk_en) |=> crc_ready);

endmodule

// File: tb/test_crc8_link_guard.sv
`timescale 1ns/1ps
module test_crc8_link_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0, byte_sof = 1'b0, byte_eof = 1'b0, byte_dir = 1'b0;
   logic [7:0] byte_dat = 8'h00;
   logic       chk_en_wr = 1'b0, chk_en_dat = 1'b0, err_clr = 1'b0;
   logic [7:0] crc_value;
   logic       crc_ready, chk_en, rx_err;

   int errors = 0;
   int checks = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_crc;
   logic       m_ready, m_en, m_err;

   always #5 clk = ~clk;

   crc8_link_guard i_crc8_link_guard (
      .clk(clk), .rst_n(rst_n),
      .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_eof(byte_eof),
      .byte_dir(byte_dir), .byte_dat(byte_dat),
      .chk_en_wr(chk_en_wr), .chk_en_dat(chk_en_dat), .err_clr(err_clr),
      .crc_value(crc_value), .crc_ready(crc_ready), .chk_en(chk_en), .rx_err(rx_err)
   );

   function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c ^ d;
      for (int k = 0; k < 8; k++) begin
         if (r[7]) r = (r << 1) ^ 8'h07;
         else      r = r << 1;
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_crc = 8'h00; m_ready = 1'b0; m_en = 1'b1; m_err = 1'b0;
      end else begin
         logic [7:0] prior;
         prior = byte_sof ? 8'h00 : m_crc;
         m_ready = byte_vld && byte_eof && !byte_dir;
         if (byte_vld && byte_eof && byte_dir && m_en && (byte_dat != prior)) m_err = 1'b1;
         else if (err_clr) m_err = 1'b0;
         if (byte_vld) m_crc = ref_crc(prior, byte_dat);
         if (chk_en_wr) m_en = chk_en_dat;
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the reference model
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check("R1 R3 crc_value per cycle", crc_value, m_crc);
         check("R4 crc_ready per cycle", {7'd0, crc_ready}, {7'd0, m_ready});
         check("R6 chk_en per cycle", {7'd0, chk_en}, {7'd0, m_en});
         check("R7 R9 rx_err per cycle", {7'd0, rx_err}, {7'd0, m_err});
      end
   end

   task automatic send(input logic [7:0] d, input bit sof, input bit eof, input bit dir);
      @(negedge clk); #1;
      byte_vld = 1'b1; byte_sof = sof; byte_eof = eof; byte_dir = dir; byte_dat = d;
   endtask

   task automatic idle();
      @(negedge clk); #1;
      byte_vld = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0; byte_dat = 8'h00;
      chk_en_wr = 1'b0; err_clr = 1'b0;
   endtask

   task automatic frame(input logic [7:0] q[$], input bit dir);
      for (int k = 0; k < q.size(); k++) send(q[k], k == 0, k == q.size() - 1, dir);
   endtask

   task automatic write_en(input bit v);
      @(negedge clk); #1; chk_en_wr = 1'b1; chk_en_dat = v;
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] q[$];
      logic [7:0] txc;
      repeat (3) @(negedge clk);
      check("R6 reset chk_en", {7'd0, chk_en}, 8'h01);
      check("R1 reset crc_value", crc_value, 8'h00);
      check("R9 reset rx_err", {7'd0, rx_err}, 8'h00);
      check("R4 reset crc_ready", {7'd0, crc_ready}, 8'h00);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;

      // R2: one control byte alone
      send(8'h01, 1, 1, 0); idle();
      check("R2 control byte crc", crc_value, 8'h07);
      check("R4 ready after tx eof", {7'd0, crc_ready}, 8'h01);

      // R1: check string
      q = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      frame(q, 0); idle();
      check("R1 check value", crc_value, 8'hF4);
      repeat (3) idle();
      check("R3 hold while idle", crc_value, 8'hF4);

      // R10: random frame then its own CRC on receive
      q = {};
      for (int k = 0; k < 6; k++) q.push_back(8'($urandom));
      frame(q, 0); idle();
      txc = crc_value;
      q.push_back(txc);
      frame(q, 1); idle();
      check("R10 residue zero", crc_value, 8'h00);
      check("R10 no error on good frame", {7'd0, rx_err}, 8'h00);

      // R7: corrupted CRC byte
      q[q.size()-1] = txc ^ 8'h10;
      frame(q, 1); idle();
      check("R7 mismatch sets error", {7'd0, rx_err}, 8'h01);
      repeat (4) idle();
      check("R9 error is sticky", {7'd0, rx_err}, 8'h01);
      @(negedge clk); #1 err_clr = 1'b1;
      idle();
      check("R9 clear", {7'd0, rx_err}, 8'h00);

      // R6 / R8 / R5: disabled
      write_en(0);
      check("R6 written zero", {7'd0, chk_en}, 8'h00);
      frame(q, 1); idle();
      check("R8 no error while disabled", {7'd0, rx_err}, 8'h00);
      q = {8'h01};
      frame(q, 0); idle();
      check("R5 tx crc while disabled", crc_value, 8'h07);
      check("R5 ready while disabled", {7'd0, crc_ready}, 8'h01);
      write_en(1);
      check("R6 written one", {7'd0, chk_en}, 8'h01);

      // R11: single-byte receive frames
      send(8'h00, 1, 1, 1); idle();
      check("R11 single byte match", {7'd0, rx_err}, 8'h00);
      send(8'h5A, 1, 1, 1); idle();
      check("R11 single byte mismatch", {7'd0, rx_err}, 8'h01);

      // R9: set beats clear in the same cycle
      @(negedge clk); #1 err_clr = 1'b1;
      idle();
      send(8'h33, 1, 1, 1); err_clr = 1'b1; idle();
      check("R9 set wins over clear", {7'd0, rx_err}, 8'h01);
      @(negedge clk); #1 err_clr = 1'b1;
      idle();

      // R3: back-to-back frames, receive then transmit with no gap
      q = {8'hA5, 8'h3C, 8'hFF};
      frame(q, 1); frame(q, 0); idle();
      check("R3 back-to-back tx crc", crc_value,
            ref_crc(ref_crc(ref_crc(8'h00, 8'hA5), 8'h3C), 8'hFF));
      idle();
      check("R4 ready single pulse", {7'd0, crc_ready}, 8'h00);

      repeat (3) idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule